// File: doc/BRIEF.md
# Serial 4B/5B Receive Symbol Decoder

This block sits after clock recovery and descrambling in a 100 Mb/s receive path. It takes one recovered bit per clock. While the line is idle it searches for the start-of-stream delimiter pair J/K. When the pair is found, it locks the 5-bit code-group boundary and turns every following code group into a 4-bit nibble. These nibbles appear on a media-independent receive interface, together with data-valid, error and carrier-sense outputs. A nibble strobe marks each nibble, and the strobe runs at one fifth of the bit rate.

The delimiter pair is replaced by two preamble nibbles. The stream ends on the end-of-stream pair T/R. A premature return to idle, a bad ending and any non-data code inside the frame are all flagged on the error output. A carrier that starts after idle but does not open with J/K is a false carrier. It is reported with the error output and a fixed nibble, with data-valid held low, and it increments a saturating event counter. After every frame or false carrier the block goes back to searching.

Top module: `sym5_rx_decoder`

## Requirements
- R1: A candidate start is a zero bit that arrives after at least seven consecutive ones. That zero is taken as the third bit of J. A J/K pair that is not preceded by such an idle run produces no output and leaves `rx_crs` low.
- R2: When the 10 bits of a candidate are J then K (first-received bit is the code MSB: J=11000, K=10001), the first two nibbles delivered are 0101 and 0101, with `rx_dv`=1, `rx_er`=0 and `rx_crs`=1.
- R3: After J/K, each data code group is delivered as its nibble, one strobe after the group completes, with `rx_dv`=1 and `rx_er`=0. The codes are 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101.
- R4: T (01101) followed by R (00111) ends the frame. The last data nibble is delivered at the T strobe, and at the R strobe `rx_dv` and `rx_crs` fall. If T is followed by any other group, that strobe instead delivers nibble 0000 with `rx_dv`=1, `rx_er`=1 and `rx_crs`=0.
- R5: An IDLE group (11111) inside a frame ends it. The pending last nibble is delivered with `rx_dv`=1, `rx_er`=1 and `rx_crs`=0.
- R6: A non-data code group inside a frame (other than T or IDLE) is delivered as nibble 0000 with `rx_dv`=1 and `rx_er`=1.
- R7: A candidate whose 10 bits are not J/K is a false carrier. On that strobe and on each later strobe until an aligned IDLE group arrives, the outputs are `rx_er`=1, nibble 1110, `rx_dv`=0 and `rx_crs`=1. The outputs return to zero when the IDLE group arrives.
- R8: Each false carrier increments `fc_count` by one, and the counter holds at 255.
- R9: `rx_crs` rises no later than 10 bit periods after the first bit of J is presented.
- R10: While carrier is up, `rx_stb` pulses for one cycle every 5 clocks. `rxd`, `rx_dv`, `rx_er` and `rx_crs` change only in strobe cycles.
- R11: A new frame that follows the previous R after a single IDLE group is aligned and decoded.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one recovered bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Descrambled serial bit |
| rx_stb | output | 1 | One-cycle pulse marking a new nibble |
| rxd | output | 4 | Received nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rx_crs | output | 1 | Carrier sense |
| fc_count | output | 8 | Saturating false-carrier event count |

## Verification
Frames carrying every data nibble in order, plus a second frame with a mixed nibble pattern sent after only one idle group, show that the table and the re-search after T/R are both correct. Frames ending in a premature IDLE, in T followed by a non-R code, or carrying a stray control code inside the frame separate the three error endings from a clean T/R close. A J/K pair sent straight after R without an idle run must produce nothing, which shows that alignment really depends on idle. Repeated non-J/K carriers tell false carriers apart from frames and push the event counter past its limit to show that it saturates.

// File: rtl/sym5_pkg.sv
package sym5_pkg;

    localparam int GRP_W = 5;
    localparam int NIB_W = 4;

    localparam logic [GRP_W-1:0] C_IDLE = 5'b11111;
    localparam logic [GRP_W-1:0] C_J    = 5'b11000;
    localparam logic [GRP_W-1:0] C_K    = 5'b10001;
    localparam logic [GRP_W-1:0] C_T    = 5'b01101;
    localparam logic [GRP_W-1:0] C_R    = 5'b00111;

    localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_FC  = 4'b1110;

    typedef enum logic [1:0] {
        ST_SEARCH,
        ST_CAND,
        ST_DATA,
        ST_FCAR
    } rx_state_e;

    typedef struct packed {
        logic             crs;
        logic             dv;
        logic             er;
        logic [NIB_W-1:0] nib;
    } mii_out_t;

    typedef struct packed {
        logic             err;
        logic [NIB_W-1:0] nib;
    } pend_t;

    typedef struct packed {
        logic             hit;
        logic [NIB_W-1:0] nib;
    } look_t;

    function automatic look_t lookup5(input logic [GRP_W-1:0] g);
        look_t r;
        r.hit = 1'b1;
        case (g)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            default: begin
                r.hit = 1'b0;
                r.nib = '0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sym5_align.sv
module sym5_align
    import sym5_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_bit,
    input  logic               search_en,
    output logic               bnd,
    output logic               start,
    output logic [2*GRP_W-1:0] pair
);
    localparam int PAIR_W  = 2 * GRP_W;
    localparam int RUN_MIN = GRP_W + 2;
    localparam int RUN_W   = $clog2(RUN_MIN + 1);
    localparam int CNT_W   = $clog2(PAIR_W);
    localparam int LEFT_IN_PAIR = PAIR_W - 3;

    logic [PAIR_W-2:0] hist;
    logic [RUN_W-1:0]  run;
    logic [CNT_W-1:0]  cnt;

    assign pair  = {hist, rx_bit};
    assign bnd   = (cnt == CNT_W'(1));
    assign start = search_en && !rx_bit && (run >= RUN_W'(RUN_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            run  <= '0;
            cnt  <= CNT_W'(GRP_W);
        end else begin
            hist <= pair[PAIR_W-2:0];
            if (!rx_bit)
                run <= '0;
            else if (run != RUN_W'(RUN_MIN))
                run <= run + 1'b1;
            if (start)
                cnt <= CNT_W'(LEFT_IN_PAIR);
            else if (bnd)
                cnt <= CNT_W'(GRP_W);
            else
                cnt <= cnt - 1'b1;
        end
    end

    p_cnt_live_r10: assert property (@(posedge clk) disable iff (rst)
        bnd |=> !bnd);

endmodule

// File: rtl/sym5_fsm.sv
module sym5_fsm
    import sym5_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bnd,
    input  logic               start,
    input  logic [2*GRP_W-1:0] pair,
    output logic               search_en,
    output mii_out_t           out,
    output logic               stb,
    output logic               fc_evt
);
    localparam logic [2*GRP_W-1:0] JK_PAIR = {C_J, C_K};

    rx_state_e        state;
    pend_t            pend;
    logic             saw_t;
    logic [GRP_W-1:0] g;
    look_t            look;

    assign g         = pair[GRP_W-1:0];
    assign look      = lookup5(g);
    assign search_en = (state == ST_SEARCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_SEARCH;
            out    <= '0;
            pend   <= '0;
            saw_t  <= 1'b0;
            stb    <= 1'b0;
            fc_evt <= 1'b0;
        end else begin
            stb    <= bnd;
            fc_evt <= 1'b0;
            case (state)
                ST_SEARCH: begin
                    if (bnd)
                        out <= '0;
                    if (start)
                        state <= ST_CAND;
                end
                ST_CAND: begin
                    if (bnd) begin
                        if (pair == JK_PAIR) begin
                            state <= ST_DATA;
                            out   <= '{crs: 1'b1, dv: 1'b1, er: 1'b0, nib: NIB_PRE};
                            pend  <= '{err: 1'b0, nib: NIB_PRE};
                            saw_t <= 1'b0;
                        end else begin
                            state  <= ST_FCAR;
                            out    <= '{crs: 1'b1, dv: 1'b0, er: 1'b1, nib: NIB_FC};
                            fc_evt <= 1'b1;
                        end
                    end
                end
                ST_FCAR: begin
                    if (bnd) begin
                        if (g == C_IDLE) begin
                            state <= ST_SEARCH;
                            out   <= '0;
                        end else begin
                            out <= '{crs: 1'b1, dv: 1'b0, er: 1'b1, nib: NIB_FC};
                        end
                    end
                end
                ST_DATA: begin
                    if (bnd) begin
                        if (saw_t) begin
                            state <= ST_SEARCH;
                            saw_t <= 1'b0;
                            if (g == C_R)
                                out <= '0;
                            else
                                out <= '{crs: 1'b0, dv: 1'b1, er: 1'b1, nib: '0};
                        end else if (g == C_IDLE) begin
                            state <= ST_SEARCH;
                            out   <= '{crs: 1'b0, dv: 1'b1, er: 1'b1, nib: pend.nib};
                        end else if (g == C_T) begin
                            out   <= '{crs: 1'b1, dv: 1'b1, er: pend.err, nib: pend.nib};
                            saw_t <= 1'b1;
                        end else begin
                            out  <= '{crs: 1'b1, dv: 1'b1, er: pend.err, nib: pend.nib};
                            pend <= '{err: !look.hit, nib: look.nib};
                        end
                    end
                end
                default: state <= ST_SEARCH;
            endcase
        end
    end

    p_preamble_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(out.dv) |-> (out.nib == NIB_PRE && !out.er));

    p_false_carrier_code_r7: assert property (@(posedge clk) disable iff (rst)
        (out.er && !out.dv) |-> (out.nib == NIB_FC && out.crs));

    p_quiet_between_r10: assert property (@(posedge clk) disable iff (rst)
        !stb |-> $stable(out));

    p_fc_single_r8: assert property (@(posedge clk) disable iff (rst)
        fc_evt |=> !fc_evt);

endmodule

// File: rtl/sym5_fc_count.sv
module sym5_fc_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (inc && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/sym5_rx_decoder.sv
module sym5_rx_decoder
    import sym5_pkg::*;
#(
    parameter int FC_CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_bit,
    output logic                rx_stb,
    output logic [NIB_W-1:0]    rxd,
    output logic                rx_dv,
    output logic                rx_er,
    output logic                rx_crs,
    output logic [FC_CNT_W-1:0] fc_count
);
    logic               bnd;
    logic               start;
    logic               search_en;
    logic               fc_evt;
    logic [2*GRP_W-1:0] pair;
    mii_out_t           out;

    sym5_align u_align (
        .clk       (clk),
        .rst       (rst),
        .rx_bit    (rx_bit),
        .search_en (search_en),
        .bnd       (bnd),
        .start     (start),
        .pair      (pair)
    );

    sym5_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bnd       (bnd),
        .start     (start),
        .pair      (pair),
        .search_en (search_en),
        .out       (out),
        .stb       (rx_stb),
        .fc_evt    (fc_evt)
    );

    sym5_fc_count #(.CNT_W(FC_CNT_W)) u_fc (
        .clk   (clk),
        .rst   (rst),
        .inc   (fc_evt),
        .count (fc_count)
    );

    assign rxd    = out.nib;
    assign rx_dv  = out.dv;
    assign rx_er  = out.er;
    assign rx_crs = out.crs;

    p_crs_drop_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_crs) |-> rx_stb);

    p_crs_rise_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_crs) |-> rx_stb);

endmodule

// File: tb/sym5_rx_decoder_tb.sv
module sym5_rx_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b1;
    logic       rx_stb;
    logic [3:0] rxd;
    logic       rx_dv;
    logic       rx_er;
    logic       rx_crs;
    logic [7:0] fc_count;

    always #10 clk = ~clk;

    sym5_rx_decoder u_dut (
        .clk      (clk),
        .rst      (rst),
        .rx_bit   (rx_bit),
        .rx_stb   (rx_stb),
        .rxd      (rxd),
        .rx_dv    (rx_dv),
        .rx_er    (rx_er),
        .rx_crs   (rx_crs),
        .fc_count (fc_count)
    );

    typedef struct {
        logic [6:0] v;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   j_cyc  = 0;
    int   last_stb = 0;
    logic prev_stb_crs = 1'b0;
    logic crs_q = 1'b0;
    logic [6:0] prev_vec = '0;
    logic done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110;  4'h1: return 5'b01001;
            4'h2: return 5'b10100;  4'h3: return 5'b10101;
            4'h4: return 5'b01010;  4'h5: return 5'b01011;
            4'h6: return 5'b01110;  4'h7: return 5'b01111;
            4'h8: return 5'b10010;  4'h9: return 5'b10011;
            4'hA: return 5'b10110;  4'hB: return 5'b10111;
            4'hC: return 5'b11010;  4'hD: return 5'b11011;
            4'hE: return 5'b11100;  default: return 5'b11101;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic crs, input logic dv, input logic er, input logic [3:0] n, input string tag);
        exp_t e;
        e.v   = {crs, dv, er, n};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic send_grp(input logic [4:0] g, input logic mark);
        for (int i = 4; i >= 0; i--) begin
            @(negedge clk);
            rx_bit = g[i];
            if (mark && i == 4) j_cyc = cyc;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_grp(5'b11111, 1'b0);
    endtask

    task automatic pkt_start();
        push(1, 1, 0, 4'b0101, "R2");
        push(1, 1, 0, 4'b0101, "R2");
        send_grp(5'b11000, 1'b1);
        send_grp(5'b10001, 1'b0);
    endtask

    task automatic pkt_data(input logic [3:0] n, input string tag);
        push(1, 1, 0, n, tag);
        send_grp(enc(n), 1'b0);
    endtask

    task automatic pkt_end_tr();
        send_grp(5'b01101, 1'b0);
        send_grp(5'b00111, 1'b0);
    endtask

    task automatic fcar(input int extra);
        push(1, 0, 1, 4'b1110, "R7");
        send_grp(5'b11010, 1'b1);
        send_grp(5'b10100, 1'b0);
        for (int i = 0; i < extra; i++) begin
            push(1, 0, 1, 4'b1110, "R7");
            send_grp(5'b01111, 1'b0);
        end
        idle(1);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (!rx_stb)
                check({rx_crs, rx_dv, rx_er, rxd} == prev_vec, "R10 change off strobe",
                      {rx_crs, rx_dv, rx_er, rxd}, prev_vec);
            if (rx_stb) begin
                if (prev_stb_crs)
                    check(cyc - last_stb == 5, "R10 strobe spacing", cyc - last_stb, 5);
                last_stb     = cyc;
                prev_stb_crs = rx_crs;
                if (rx_dv || rx_er || rx_crs) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R1 unexpected nibble", {rx_crs, rx_dv, rx_er, rxd}, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check({rx_crs, rx_dv, rx_er, rxd} == e.v, e.tag,
                              {rx_crs, rx_dv, rx_er, rxd}, e.v);
                    end
                end
            end
            if (rx_crs && !crs_q)
                check(cyc - j_cyc <= 10, "R9 carrier latency", cyc - j_cyc, 10);
            crs_q    = rx_crs;
            prev_vec = {rx_crs, rx_dv, rx_er, rxd};
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cycles(5);
        check({rx_stb, rx_crs, rx_dv, rx_er, rxd} == 0, "R12 reset outputs",
              {rx_stb, rx_crs, rx_dv, rx_er, rxd}, 0);
        check(fc_count == 0, "R12 reset count", fc_count, 0);
        rst = 1'b0;
        idle(3);

        // all sixteen nibbles, clean T/R close
        pkt_start();
        for (int n = 0; n < 16; n++) pkt_data(4'(n), "R3");
        pkt_end_tr();
        idle(1);

        // R11: new frame after a single idle group
        pkt_start();
        pkt_data(4'hA, "R11");
        pkt_data(4'h5, "R11");
        pkt_data(4'h3, "R11");
        pkt_data(4'hC, "R11");
        pkt_end_tr();

        // R1: J/K straight after R, no idle run: ignored
        send_grp(5'b11000, 1'b0);
        send_grp(5'b10001, 1'b0);
        send_grp(enc(4'h5), 1'b0);
        send_grp(enc(4'h5), 1'b0);
        send_grp(enc(4'h5), 1'b0);
        pkt_end_tr();
        idle(2);
        check(rx_crs == 1'b0, "R1 crs low", rx_crs, 0);
        check(q.size() == 0, "R1 nothing pending", q.size(), 0);

        // R6: stray control code inside the frame
        pkt_start();
        pkt_data(4'h9, "R6");
        push(1, 1, 1, 4'h0, "R6");
        send_grp(5'b00100, 1'b0);
        pkt_data(4'h6, "R6");
        pkt_end_tr();
        idle(2);

        // R5: premature idle
        pkt_start();
        pkt_data(4'h2, "R5");
        push(0, 1, 1, 4'hB, "R5");
        send_grp(enc(4'hB), 1'b0);
        idle(2);

        // R4: T followed by a non-R group
        pkt_start();
        pkt_data(4'h7, "R4");
        push(0, 1, 1, 4'h0, "R4");
        send_grp(5'b01101, 1'b0);
        send_grp(5'b00100, 1'b0);
        idle(2);

        // R7: false carrier with two trailing non-idle groups
        check(fc_count == 0, "R8 count before", fc_count, 0);
        fcar(2);
        idle(1);
        check(fc_count == 1, "R8 count one", fc_count, 1);

        // R8: saturation
        for (int i = 0; i < 258; i++) fcar(0);
        idle(1);
        check(fc_count == 8'hFF, "R8 saturate", fc_count, 8'hFF);

        // a clean frame still decodes after many false carriers
        pkt_start();
        pkt_data(4'hE, "R3");
        pkt_data(4'h1, "R3");
        pkt_end_tr();
        idle(4);
        wait_cycles(20);
        check(q.size() == 0, "R3 all expected nibbles seen", q.size(), 0);
        check(rx_crs == 1'b0 && rx_dv == 1'b0, "R4 idle at end", {rx_crs, rx_dv}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule